// File: doc/BRIEF.md
# Shared-Pin GPIO Port Multiplexer

This block manages an eight-pin general-purpose I/O port. Two other functions can claim its pins: an analog converter that can sample any one of the eight pins, and a two-channel timer that can use the top two pins for capture or compare. Each pin has one data latch bit and one direction bit, both reached over a small register bus. For every pin the block decides which function owns it. That decision sets the tri-state drive (`pin_out`, `pin_oe`), the converter connect strobe (`adc_conn`) and the gated timer capture input (`tmr_cap`). It also sets what a read of the data register returns for that bit.

Owner priority, from highest to lowest, is converter, then timer, then plain GPIO. The converter owns the pin whose index equals `adc_chan`. A timer channel owns its pin when its 2-bit edge/level field in `tmr_mode` is nonzero. For pins 6 and 7, the field sits at `tmr_mode[1:0]` and `tmr_mode[3:2]` respectively. Pin inputs go through a two-flop synchronizer before they are read back or passed to the timer.

Reads are served by a two-state bus sequencer. `BUS_IDLE` moves to `BUS_RESP` on a read request, and the captured data is presented with `bus_rvalid` for one cycle. `BUS_RESP` moves back to `BUS_IDLE` when no read follows, or stays in `BUS_RESP` when another read is requested at once. Writes take effect at the clock edge that samples them and give no response.

Top module: `gpm_port`

## Requirements
- R1: A write to the data register (offset 1) updates all eight latch bits at the sampling edge, whatever the owner of each pin. A read of a bit whose direction bit is 1 returns the latch bit.
- R2: Reset clears the direction register (offset 5) to all zeros. With no timer field set and no converter pin selected, every `pin_oe` bit is 0 after reset.
- R3: On a GPIO-owned pin, `pin_oe` equals the direction bit and `pin_out` equals the latch bit.
- R4: A read request (`bus_sel`=1, `bus_wr`=0) gives `bus_rvalid`=1 with the data in the next cycle. A GPIO or timer input bit (direction 0) reads the pin level through a two-flop synchronizer, so a read requested in the same cycle as a pin change returns the old level.
- R5: An `adc_chan` value of 0 to 7 hands exactly that pin to the converter. `adc_conn` then has that single bit set, and the pin's `pin_oe` is 0. Values 8 to 31 hand no pin to the converter, and `adc_conn` is 0.
- R6: A converter-owned pin with direction 0 reads 0. With direction 1 it reads the latch bit.
- R7: Pin 6 is timer-owned when `tmr_mode[1:0]`≠0, and pin 7 when `tmr_mode[3:2]`≠0. On a timer-owned pin, `pin_out`/`pin_oe` follow `tmr_out`/`tmr_oe` of that channel, and the direction bit has no effect on the drive.
- R8: A timer-owned pin reads the latch bit when its direction bit is 1 and the synchronized pin level when it is 0.
- R9: `tmr_cap` of a channel carries the synchronized pin level while its pin is timer-owned and is 0 otherwise.
- R10: When the converter selects a pin whose timer field is nonzero, the converter owns it. The pin is not driven, and that channel's `tmr_cap` is 0.
- R11: Reset leaves the data latch contents unchanged.
- R12: Reads of offsets other than 1 and 5 return 0. Writes to those offsets change neither register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Bus access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 3 | Register offset |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid with bus_rvalid |
| bus_rvalid | output | 1 | Read response strobe |
| pin_in | input | 8 | Pin levels (asynchronous) |
| pin_out | output | 8 | Pin drive values |
| pin_oe | output | 8 | Pin drive enables |
| adc_chan | input | 5 | Converter channel select |
| adc_conn | output | 8 | One-hot converter pin connect |
| tmr_mode | input | 4 | Edge/level fields, 2 bits per timer channel |
| tmr_out | input | 2 | Timer compare outputs |
| tmr_oe | input | 2 | Timer output enables |
| tmr_cap | output | 2 | Gated synchronized capture inputs |

## Verification
The bench builds the block with its default parameters: eight pins, a 5-bit channel select, two timer channels on pins 6 and 7, and data and direction offsets 1 and 5. With these values every select code boundary can be reached from the bench: channel 7 versus 8, and a converter claim on a timer pin. The two pins where all three owners overlap can also be driven. The three-bit address reaches the unmapped offsets. The synchronizer depth is fixed at two, so the bench can check that a read issued in the same cycle as a pin change still returns the old level.

// File: rtl/gpm_pkg.sv
package gpm_pkg;

    typedef enum logic [1:0] {
        OWN_GPIO  = 2'd0,
        OWN_TIMER = 2'd1,
        OWN_ADC   = 2'd2
    } owner_e;

    typedef enum logic {
        BUS_IDLE = 1'b0,
        BUS_RESP = 1'b1
    } bus_state_e;

endpackage

// File: rtl/gpm_sync.sv
module gpm_sync #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] sync_o
);
    logic [W-1:0] stage1_q;
    logic [W-1:0] stage2_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage1_q <= '0;
            stage2_q <= '0;
        end else begin
            stage1_q <= async_i;
            stage2_q <= stage1_q;
        end
    end

    assign sync_o = stage2_q;
endmodule

// File: rtl/gpm_owner.sv
module gpm_owner
    import gpm_pkg::*;
#(
    parameter int NPINS  = 8,
    parameter int SEL_W  = 5,
    parameter int TMR_CH = 2,
    parameter int MODE_W = 2
) (
    input  logic [SEL_W-1:0]         adc_chan,
    input  logic [TMR_CH*MODE_W-1:0] tmr_mode,
    output owner_e                   owner_o [NPINS]
);
    localparam int TMR_BASE = NPINS - TMR_CH;

    for (genvar i = 0; i < NPINS; i++) begin : g_pin
        logic adc_hit;
        logic tmr_hit;

        assign adc_hit = (adc_chan == SEL_W'(i));

        if (i >= TMR_BASE) begin : g_tmr
            assign tmr_hit = |tmr_mode[(i-TMR_BASE)*MODE_W +: MODE_W];
        end else begin : g_plain
            assign tmr_hit = 1'b0;
        end

        always_comb begin
            if (adc_hit) begin
                owner_o[i] = OWN_ADC;
            end else if (tmr_hit) begin
                owner_o[i] = OWN_TIMER;
            end else begin
                owner_o[i] = OWN_GPIO;
            end
        end
    end
endmodule

// File: rtl/gpm_pin_mux.sv
module gpm_pin_mux
    import gpm_pkg::*;
#(
    parameter int NPINS  = 8,
    parameter int TMR_CH = 2
) (
    input  owner_e            owner_i [NPINS],
    input  logic [NPINS-1:0]  latch_i,
    input  logic [NPINS-1:0]  dir_i,
    input  logic [NPINS-1:0]  pin_sync_i,
    input  logic [TMR_CH-1:0] tmr_out,
    input  logic [TMR_CH-1:0] tmr_oe,
    output logic [NPINS-1:0]  pin_out,
    output logic [NPINS-1:0]  pin_oe,
    output logic [NPINS-1:0]  adc_conn,
    output logic [TMR_CH-1:0] tmr_cap,
    output logic [NPINS-1:0]  rd_view
);
    localparam int TMR_BASE = NPINS - TMR_CH;

    for (genvar i = 0; i < NPINS; i++) begin : g_pin
        logic t_out;
        logic t_oe;

        if (i >= TMR_BASE) begin : g_tmr
            assign t_out = tmr_out[i-TMR_BASE];
            assign t_oe  = tmr_oe[i-TMR_BASE];
            assign tmr_cap[i-TMR_BASE] = (owner_i[i] == OWN_TIMER) ? pin_sync_i[i] : 1'b0;
        end else begin : g_plain
            assign t_out = 1'b0;
            assign t_oe  = 1'b0;
        end

        // drive and converter connect
        always_comb begin
            unique case (owner_i[i])
                OWN_ADC: begin
                    pin_out[i]  = 1'b0;
                    pin_oe[i]   = 1'b0;
                    adc_conn[i] = 1'b1;
                end
                OWN_TIMER: begin
                    pin_out[i]  = t_out;
                    pin_oe[i]   = t_oe;
                    adc_conn[i] = 1'b0;
                end
                default: begin
                    pin_out[i]  = latch_i[i];
                    pin_oe[i]   = dir_i[i];
                    adc_conn[i] = 1'b0;
                end
            endcase
        end

        // readback image: direction selects source, never the drive
        always_comb begin
            if (dir_i[i]) begin
                rd_view[i] = latch_i[i];
            end else begin
                unique case (owner_i[i])
                    OWN_ADC:   rd_view[i] = 1'b0;
                    OWN_TIMER: rd_view[i] = pin_sync_i[i];
                    default:   rd_view[i] = pin_sync_i[i];
                endcase
            end
        end
    end
endmodule

// File: rtl/gpm_regs.sv
module gpm_regs
    import gpm_pkg::*;
#(
    parameter int NPINS    = 8,
    parameter int ADDR_W   = 3,
    parameter int DATA_OFS = 1,
    parameter int DIR_OFS  = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [NPINS-1:0]  bus_wdata,
    input  logic [NPINS-1:0]  rd_view,
    output logic [NPINS-1:0]  bus_rdata,
    output logic              bus_rvalid,
    output logic [NPINS-1:0]  latch_q,
    output logic [NPINS-1:0]  dir_q
);
    localparam logic [ADDR_W-1:0] A_DATA = ADDR_W'(DATA_OFS);
    localparam logic [ADDR_W-1:0] A_DIR  = ADDR_W'(DIR_OFS);

    bus_state_e       state_q, state_d;
    logic             wr_req, rd_req;
    logic [NPINS-1:0] rd_mux;
    logic [NPINS-1:0] rdata_q;

    assign wr_req = bus_sel && bus_wr;
    assign rd_req = bus_sel && !bus_wr;

    // data latch: deliberately without reset
    always_ff @(posedge clk) begin
        if (wr_req && bus_addr == A_DATA) begin
            latch_q <= bus_wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dir_q <= '0;
        end else if (wr_req && bus_addr == A_DIR) begin
            dir_q <= bus_wdata;
        end
    end

    always_comb begin
        if (bus_addr == A_DATA) begin
            rd_mux = rd_view;
        end else if (bus_addr == A_DIR) begin
            rd_mux = dir_q;
        end else begin
            rd_mux = '0;
        end
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            BUS_IDLE: state_d = rd_req ? BUS_RESP : BUS_IDLE;
            BUS_RESP: state_d = rd_req ? BUS_RESP : BUS_IDLE;
            default:  state_d = BUS_IDLE;
        endcase
    end

    // state register and captured read data
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= BUS_IDLE;
            rdata_q <= '0;
        end else begin
            state_q <= state_d;
            if (rd_req) begin
                rdata_q <= rd_mux;
            end
        end
    end

    // outputs
    always_comb begin
        unique case (state_q)
            BUS_RESP: begin
                bus_rvalid = 1'b1;
                bus_rdata  = rdata_q;
            end
            default: begin
                bus_rvalid = 1'b0;
                bus_rdata  = '0;
            end
        endcase
    end

    p_rsp_follows_req_r4: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req |=> bus_rvalid);
    p_no_rsp_without_req_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_req |=> !bus_rvalid);
    p_latch_takes_write_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_req && bus_addr == A_DATA) |=> latch_q == $past(bus_wdata));
    p_dir_cleared_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> dir_q == '0);
    p_dir_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !(wr_req && bus_addr == A_DIR)) |=> $stable(dir_q));
endmodule

// File: rtl/gpm_port.sv
module gpm_port
    import gpm_pkg::*;
#(
    parameter int NPINS    = 8,
    parameter int SEL_W    = 5,
    parameter int TMR_CH   = 2,
    parameter int MODE_W   = 2,
    parameter int ADDR_W   = 3,
    parameter int DATA_OFS = 1,
    parameter int DIR_OFS  = 5
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     bus_sel,
    input  logic                     bus_wr,
    input  logic [ADDR_W-1:0]        bus_addr,
    input  logic [NPINS-1:0]         bus_wdata,
    output logic [NPINS-1:0]         bus_rdata,
    output logic                     bus_rvalid,
    input  logic [NPINS-1:0]         pin_in,
    output logic [NPINS-1:0]         pin_out,
    output logic [NPINS-1:0]         pin_oe,
    input  logic [SEL_W-1:0]         adc_chan,
    output logic [NPINS-1:0]         adc_conn,
    input  logic [TMR_CH*MODE_W-1:0] tmr_mode,
    input  logic [TMR_CH-1:0]        tmr_out,
    input  logic [TMR_CH-1:0]        tmr_oe,
    output logic [TMR_CH-1:0]        tmr_cap
);
    localparam int TMR_BASE = NPINS - TMR_CH;

    owner_e           owner [NPINS];
    logic [NPINS-1:0] latch_q;
    logic [NPINS-1:0] dir_q;
    logic [NPINS-1:0] pin_sync;
    logic [NPINS-1:0] rd_view;

    gpm_sync #(.W(NPINS)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (pin_in),
        .sync_o  (pin_sync)
    );

    gpm_owner #(
        .NPINS  (NPINS),
        .SEL_W  (SEL_W),
        .TMR_CH (TMR_CH),
        .MODE_W (MODE_W)
    ) u_owner (
        .adc_chan (adc_chan),
        .tmr_mode (tmr_mode),
        .owner_o  (owner)
    );

    gpm_pin_mux #(
        .NPINS  (NPINS),
        .TMR_CH (TMR_CH)
    ) u_mux (
        .owner_i    (owner),
        .latch_i    (latch_q),
        .dir_i      (dir_q),
        .pin_sync_i (pin_sync),
        .tmr_out    (tmr_out),
        .tmr_oe     (tmr_oe),
        .pin_out    (pin_out),
        .pin_oe     (pin_oe),
        .adc_conn   (adc_conn),
        .tmr_cap    (tmr_cap),
        .rd_view    (rd_view)
    );

    gpm_regs #(
        .NPINS    (NPINS),
        .ADDR_W   (ADDR_W),
        .DATA_OFS (DATA_OFS),
        .DIR_OFS  (DIR_OFS)
    ) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .bus_sel    (bus_sel),
        .bus_wr     (bus_wr),
        .bus_addr   (bus_addr),
        .bus_wdata  (bus_wdata),
        .rd_view    (rd_view),
        .bus_rdata  (bus_rdata),
        .bus_rvalid (bus_rvalid),
        .latch_q    (latch_q),
        .dir_q      (dir_q)
    );

    p_adc_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(adc_conn));
    p_adc_pin_undriven_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (adc_conn & pin_oe) == '0);
    p_adc_high_sel_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (adc_chan >= SEL_W'(NPINS)) |-> adc_conn == '0);

    for (genvar j = 0; j < TMR_CH; j++) begin : g_chk
        p_adc_cuts_capture_r10: assert property (@(posedge clk) disable iff (!rst_n)
            adc_conn[TMR_BASE+j] |-> !tmr_cap[j]);
        p_idle_field_no_capture_r9: assert property (@(posedge clk) disable iff (!rst_n)
            (tmr_mode[j*MODE_W +: MODE_W] == '0) |-> !tmr_cap[j]);
    end
endmodule

// File: tb/sim_gpm_port.sv
`timescale 1ns/1ps
module sim_gpm_port;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_sel = 1'b0;
    logic       bus_wr = 1'b0;
    logic [2:0] bus_addr = '0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic       bus_rvalid;
    logic [7:0] pin_in = '0;
    logic [7:0] pin_out;
    logic [7:0] pin_oe;
    logic [4:0] adc_chan = 5'd31;
    logic [7:0] adc_conn;
    logic [3:0] tmr_mode = '0;
    logic [1:0] tmr_out = '0;
    logic [1:0] tmr_oe = '0;
    logic [1:0] tmr_cap;

    int  checks = 0;
    int  fails = 0;
    bit  done = 1'b0;

    logic [7:0] exp_q [$];
    string      tag_q [$];

    always #2.5 clk = ~clk;

    gpm_port u0 (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .bus_rvalid(bus_rvalid), .pin_in(pin_in), .pin_out(pin_out),
        .pin_oe(pin_oe), .adc_chan(adc_chan), .adc_conn(adc_conn),
        .tmr_mode(tmr_mode), .tmr_out(tmr_out), .tmr_oe(tmr_oe),
        .tmr_cap(tmr_cap)
    );

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // monitor: pops expected read data as responses appear
    always @(negedge clk) begin
        if (rst_n && bus_rvalid) begin
            if (exp_q.size() == 0) begin
                checks++;
                fails++;
                $display("FAIL R4 unexpected response actual=%h expected=none", bus_rdata);
            end else begin
                check(tag_q.pop_front(), bus_rdata, exp_q.pop_front());
            end
        end
    end

    task automatic bus_write(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    // driver: issue a read and push the expected item
    task automatic bus_read(input logic [2:0] a, input logic [7:0] exp, input string tag);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        exp_q.push_back(exp);
        tag_q.push_back(tag);
        @(negedge clk);
        bus_sel = 1'b0;
    endtask

    task automatic settle();
        repeat (3) @(negedge clk);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    endtask

    initial begin
        #(200000 * 5);
        checks++;
        fails++;
        $display("FAIL watchdog actual=running expected=finished");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R2: reset state
        check("R2 pin_oe after reset", pin_oe, 8'h00);
        check("R4 no response at idle", {7'd0, bus_rvalid}, 8'h00);
        bus_read(3'd5, 8'h00, "R2 dir reads zero");

        // R12 / R1: register map
        bus_write(3'd5, 8'hFF);
        bus_write(3'd1, 8'hA5);
        bus_read(3'd1, 8'hA5, "R1 latch readback");
        bus_read(3'd5, 8'hFF, "R12 dir offset");
        bus_read(3'd0, 8'h00, "R12 unmapped offset 0");
        bus_write(3'd3, 8'h00);
        bus_write(3'd7, 8'h00);
        bus_read(3'd1, 8'hA5, "R12 stray write data kept");
        bus_read(3'd5, 8'hFF, "R12 stray write dir kept");

        // R3: gpio drive
        @(negedge clk);
        check("R3 oe all out", pin_oe, 8'hFF);
        check("R3 out latch", pin_out, 8'hA5);
        bus_write(3'd5, 8'h0F);
        check("R3 oe follows dir", pin_oe, 8'h0F);
        check("R3 out latch mixed", pin_out, 8'hA5);

        // R4: synchronized input read
        pin_in = 8'h3C;
        settle();
        bus_read(3'd1, 8'h35, "R4 mixed read pattern 1");
        pin_in = 8'hC3;
        settle();
        bus_read(3'd1, 8'hC5, "R4 mixed read pattern 2");
        // pin changes in the request cycle: old level still read
        @(negedge clk);
        pin_in = 8'h00;
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = 3'd1;
        exp_q.push_back(8'hC5);
        tag_q.push_back("R4 synchronizer latency");
        @(negedge clk);
        bus_sel = 1'b0;
        settle();
        bus_read(3'd1, 8'h05, "R4 new level after sync");

        // R5: converter selection
        adc_chan = 5'd2;
        @(negedge clk);
        check("R5 conn chan2", adc_conn, 8'h04);
        check("R5 oe released chan2", pin_oe, 8'h0B);
        adc_chan = 5'd7;
        @(negedge clk);
        check("R5 conn chan7", adc_conn, 8'h80);
        adc_chan = 5'd8;
        @(negedge clk);
        check("R5 conn chan8 none", adc_conn, 8'h00);
        check("R5 oe chan8", pin_oe, 8'h0F);

        // R6: converter readback
        pin_in = 8'hFF;
        adc_chan = 5'd5;
        settle();
        bus_read(3'd1, 8'hD5, "R6 converter input reads 0");
        adc_chan = 5'd0;
        @(negedge clk);
        bus_read(3'd1, 8'hF5, "R6 converter output reads latch");
        adc_chan = 5'd31;

        // R7: timer drive
        bus_write(3'd5, 8'h00);
        tmr_mode = 4'b0001; tmr_out = 2'b11; tmr_oe = 2'b01;
        @(negedge clk);
        check("R7 timer oe pin6", pin_oe, 8'h40);
        check("R7 timer out pin6", {7'd0, pin_out[6]}, 8'h01);
        bus_write(3'd5, 8'hFF);
        check("R7 dir1 timer oe on", pin_oe, 8'hFF);
        tmr_oe = 2'b00;
        @(negedge clk);
        check("R7 dir ignored on timer pin", pin_oe, 8'hBF);
        tmr_mode = 4'b1000; tmr_oe = 2'b10;
        bus_write(3'd5, 8'h00);
        check("R7 pin7 field 2", pin_oe, 8'h80);

        // R8: timer readback
        tmr_mode = 4'b0101;
        bus_write(3'd5, 8'h40);
        pin_in = 8'h80;
        settle();
        bus_read(3'd1, 8'h80, "R8 timer read pin and latch 1");
        pin_in = 8'h40;
        settle();
        bus_read(3'd1, 8'h00, "R8 timer read pin and latch 2");

        // R9: capture gating
        pin_in = 8'hC0;
        settle();
        check("R9 capture both", {6'd0, tmr_cap}, 8'h03);
        tmr_mode = 4'b0001;
        @(negedge clk);
        check("R9 capture gated pin7", {6'd0, tmr_cap}, 8'h01);

        // R10: converter beats timer
        tmr_mode = 4'b0101; tmr_oe = 2'b11;
        adc_chan = 5'd7;
        bus_write(3'd5, 8'h00);
        check("R10 pin7 undriven", pin_oe, 8'h40);
        check("R10 capture pin7 cut", {6'd0, tmr_cap}, 8'h01);
        check("R10 conn pin7", adc_conn, 8'h80);
        bus_read(3'd1, 8'h40, "R10 pin7 reads 0");

        // R1: write lands whatever the owner
        bus_write(3'd1, 8'h5A);
        bus_write(3'd5, 8'hFF);
        bus_read(3'd1, 8'h5A, "R1 latch write on claimed pins");
        adc_chan = 5'd31; tmr_mode = 4'b0000;

        // R11: latch survives reset
        bus_write(3'd1, 8'h3C);
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R2 oe after second reset", pin_oe, 8'h00);
        bus_write(3'd5, 8'hFF);
        bus_read(3'd1, 8'h3C, "R11 latch kept over reset");

        repeat (3) @(negedge clk);
        if (exp_q.size() != 0) begin
            checks++;
            fails++;
            $display("FAIL R4 missing responses actual=%0d expected=0", exp_q.size());
        end
        finish_run();
    end
endmodule